// File: doc/BRIEF.md
# Multi-Bank DRAM Read Command Scheduler

This block sits in front of one DRAM channel and decides, cycle by cycle, which DRAM command to send next for a set of pending read requests. Each request names a bank, a row and a column. Requests are stamped with an arrival age from a free-running counter and held in a small queue. The scheduler keeps a record of which row, if any, is open in each bank. It also runs a per-bank delay counter that says when that bank may accept its next command.

For every queued request the scheduler works out the one command it needs next. If the bank holds the request's row, it needs a column read. If the bank is idle, it needs a row activate. If a different row is open, it needs a precharge. Only requests whose bank delay has expired can compete. Among those, column reads beat activates and precharges, and a remaining tie goes to the oldest request. Row hits can therefore overtake older requests that still wait for row work. A request leaves the queue in the cycle its column read is sent. The command output is combinational from registered state, so a command appears in the cycle it is chosen and takes effect at the next clock edge.

Top module: `dram_sched`

## Requirements
- R1: A request offered with `req_valid` high while `req_full` is low is queued at the next edge. `req_full` is high exactly when every one of the DEPTH slots holds a request. A request offered while `req_full` is high is dropped and never produces a command.
- R2: When a queued request's bank has its row open and that request wins arbitration, the output is a column read (`cmd_type` 2'b11) carrying the request's bank, row and column. The request is removed at the following edge.
- R3: When a queued request's bank has no open row and that request wins, the output is an activate (`cmd_type` 2'b01) carrying the request's bank and row. After the edge, that row is open in that bank.
- R4: When a queued request's bank has a different row open and that request wins, the output is a precharge (`cmd_type` 2'b10) for that bank. After the edge, the bank has no open row.
- R5: A column read to a bank comes at least T_RCD cycles after the activate to that bank. An activate to a bank comes at least T_RP cycles after the precharge to that bank.
- R6: Only a request whose bank delay has expired may be served. A request to a busy bank does not stop a request to a ready bank from being served in the same cycle. No command is issued only when no queued request targets a ready bank.
- R7: Among servable requests, one that needs a column read is chosen over any that needs an activate or a precharge, even when the latter is older.
- R8: Among servable requests of equal class, the one queued earliest is chosen.
- R9: At most one command is issued per cycle (`cmd_valid` high with `cmd_type` not 2'b00). With an empty queue, `cmd_valid` is low and `cmd_type` is 2'b00.
- R10: After reset the queue is empty, every bank has no open row and is ready, `req_full` is low and no command is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request offered this cycle |
| req_bank | input | BANK_W | Bank of the offered request |
| req_row | input | ROW_W | Row of the offered request |
| req_col | input | COL_W | Column of the offered request |
| req_full | output | 1 | All queue slots occupied; offers are dropped |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_type | output | 2 | 00 none, 01 activate, 10 precharge, 11 column read |
| cmd_bank | output | BANK_W | Bank of the issued command |
| cmd_row | output | ROW_W | Row of the request being served |
| cmd_col | output | COL_W | Column of the request being served |

## Verification
A wrong open-row record shows up at once. The next command to that bank has the wrong type, for example a precharge where a read was due or a read to a closed bank, and it appears in the same cycle as the bad state. A slip in a delay counter moves a read or activate by one or more cycles against the bench's own model, and the gap checks see it on that bank's next command. A corrupted age, or a slot that is lost or never freed, shows as a different bank, row or column winning arbitration, or as `req_full` going high a cycle early or late. It can also show as a request that never gets served. All of these appear within a few cycles of the fault, because the bench compares every command against its model in every cycle.

// File: rtl/dram_sched_pkg.sv
package dram_sched_pkg;

    typedef enum logic [1:0] {
        CMD_NONE = 2'b00,
        CMD_ACT  = 2'b01,
        CMD_PRE  = 2'b10,
        CMD_RD   = 2'b11
    } cmd_e;

endpackage

// File: rtl/dram_bank_timer.sv
module dram_bank_timer #(
    parameter int ROW_W = 8,
    parameter int T_RCD = 3,
    parameter int T_RP  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_act,
    input  logic             issue_pre,
    input  logic [ROW_W-1:0] act_row,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o,
    output logic             ready_o
);
    localparam int TMAX  = (T_RCD > T_RP) ? T_RCD : T_RP;
    localparam int TMR_W = $clog2(TMAX + 1);

    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
        logic [TMR_W-1:0] tmr;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (issue_act) begin
            st_d.open = 1'b1;
            st_d.row  = act_row;
            st_d.tmr  = TMR_W'(T_RCD - 1);
        end else if (issue_pre) begin
            st_d.open = 1'b0;
            st_d.tmr  = TMR_W'(T_RP - 1);
        end else if (st_q.tmr != '0) begin
            st_d.tmr = st_q.tmr - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign open_o  = st_q.open;
    assign row_o   = st_q.row;
    assign ready_o = (st_q.tmr == '0);

    p_act_on_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        issue_act |-> (!open_o && ready_o));
    p_pre_on_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        issue_pre |-> (open_o && ready_o));
    p_act_busy_after_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_act && T_RCD > 1) |=> !ready_o);
    p_pre_busy_after_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_pre && T_RP > 1) |=> !ready_o);
    p_act_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
        issue_act |=> (open_o && row_o == $past(act_row)));
endmodule

// File: rtl/dram_req_queue.sv
module dram_req_queue #(
    parameter int DEPTH  = 8,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 8,
    parameter int COL_W  = 6,
    parameter int AGE_W  = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         enq_valid,
    input  logic [BANK_W-1:0]            enq_bank,
    input  logic [ROW_W-1:0]             enq_row,
    input  logic [COL_W-1:0]             enq_col,
    input  logic                         deq_valid,
    input  logic [$clog2(DEPTH)-1:0]     deq_idx,
    output logic                         full_o,
    output logic [DEPTH-1:0]             slot_valid,
    output logic [DEPTH-1:0][BANK_W-1:0] slot_bank,
    output logic [DEPTH-1:0][ROW_W-1:0]  slot_row,
    output logic [DEPTH-1:0][COL_W-1:0]  slot_col,
    output logic [DEPTH-1:0][AGE_W-1:0]  slot_age
);
    typedef struct packed {
        logic [DEPTH-1:0]             vld;
        logic [DEPTH-1:0][BANK_W-1:0] bank;
        logic [DEPTH-1:0][ROW_W-1:0]  row;
        logic [DEPTH-1:0][COL_W-1:0]  col;
        logic [DEPTH-1:0][AGE_W-1:0]  age;
        logic [AGE_W-1:0]             stamp;
    } q_st_t;

    q_st_t st_d, st_q;
    logic  accept;
    logic  placed;

    assign full_o = &st_q.vld;
    assign accept = enq_valid && !full_o;

    always_comb begin
        st_d   = st_q;
        placed = 1'b0;
        if (deq_valid) st_d.vld[deq_idx] = 1'b0;
        if (accept) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (!placed && !st_q.vld[i]) begin
                    placed         = 1'b1;
                    st_d.vld[i]    = 1'b1;
                    st_d.bank[i]   = enq_bank;
                    st_d.row[i]    = enq_row;
                    st_d.col[i]    = enq_col;
                    st_d.age[i]    = st_q.stamp;
                end
            end
            st_d.stamp = st_q.stamp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slot_valid = st_q.vld;
    assign slot_bank  = st_q.bank;
    assign slot_row   = st_q.row;
    assign slot_col   = st_q.col;
    assign slot_age   = st_q.age;

    p_full_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !deq_valid) |=> $stable(slot_valid));
    p_enq_grows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !deq_valid) |=> ($countones(slot_valid) == $past($countones(slot_valid)) + 1));
    p_deq_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
        deq_valid |-> slot_valid[deq_idx]);
endmodule

// File: rtl/dram_cmd_pick.sv
module dram_cmd_pick
    import dram_sched_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 8,
    parameter int AGE_W     = 16,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int IDX_W    = $clog2(DEPTH)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [DEPTH-1:0]                slot_valid,
    input  logic [DEPTH-1:0][BANK_W-1:0]    slot_bank,
    input  logic [DEPTH-1:0][ROW_W-1:0]     slot_row,
    input  logic [DEPTH-1:0][AGE_W-1:0]     slot_age,
    input  logic [NUM_BANKS-1:0]            bank_open,
    input  logic [NUM_BANKS-1:0][ROW_W-1:0] bank_row,
    input  logic [NUM_BANKS-1:0]            bank_ready,
    output logic                            pick_valid,
    output logic [IDX_W-1:0]                pick_idx,
    output cmd_e                            pick_cmd
);
    function automatic logic is_older(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
        logic [AGE_W-1:0] diff;
        diff = a - b;
        return diff[AGE_W-1];
    endfunction

    logic [AGE_W-1:0] best_age;
    logic             best_rd;
    cmd_e             need;
    logic             take;

    always_comb begin
        pick_valid = 1'b0;
        pick_idx   = '0;
        pick_cmd   = CMD_NONE;
        best_age   = '0;
        best_rd    = 1'b0;
        need       = CMD_NONE;
        take       = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!bank_open[slot_bank[i]])                      need = CMD_ACT;
            else if (bank_row[slot_bank[i]] == slot_row[i])    need = CMD_RD;
            else                                               need = CMD_PRE;
            take = 1'b0;
            if (slot_valid[i] && bank_ready[slot_bank[i]]) begin
                if (!pick_valid)                             take = 1'b1;
                else if ((need == CMD_RD) != best_rd)        take = (need == CMD_RD);
                else                                         take = is_older(slot_age[i], best_age);
            end
            if (take) begin
                pick_valid = 1'b1;
                pick_idx   = IDX_W'(i);
                pick_cmd   = need;
                best_age   = slot_age[i];
                best_rd    = (need == CMD_RD);
            end
        end
    end

    p_pick_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> (slot_valid[pick_idx] && bank_ready[slot_bank[pick_idx]]));
    p_idle_only_if_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pick_valid |-> ((slot_valid & {DEPTH{1'b1}}) == '0 || !bank_ready[slot_bank[0]] || !slot_valid[0]));
endmodule

// File: rtl/dram_sched.sv
module dram_sched
    import dram_sched_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 8,
    parameter int COL_W     = 6,
    parameter int AGE_W     = 16,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 2,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int IDX_W    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    output logic              req_full,
    output logic              cmd_valid,
    output logic [1:0]        cmd_type,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col
);
    logic [DEPTH-1:0]                slot_valid;
    logic [DEPTH-1:0][BANK_W-1:0]    slot_bank;
    logic [DEPTH-1:0][ROW_W-1:0]     slot_row;
    logic [DEPTH-1:0][COL_W-1:0]     slot_col;
    logic [DEPTH-1:0][AGE_W-1:0]     slot_age;
    logic [NUM_BANKS-1:0]            bank_open;
    logic [NUM_BANKS-1:0][ROW_W-1:0] bank_row;
    logic [NUM_BANKS-1:0]            bank_ready;
    logic [NUM_BANKS-1:0]            issue_act;
    logic [NUM_BANKS-1:0]            issue_pre;
    logic                            pick_valid;
    logic [IDX_W-1:0]                pick_idx;
    cmd_e                            pick_cmd;
    logic                            deq_valid;

    dram_req_queue #(
        .DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .AGE_W(AGE_W)
    ) u_queue (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(req_valid), .enq_bank(req_bank), .enq_row(req_row), .enq_col(req_col),
        .deq_valid(deq_valid), .deq_idx(pick_idx),
        .full_o(req_full),
        .slot_valid(slot_valid), .slot_bank(slot_bank), .slot_row(slot_row),
        .slot_col(slot_col), .slot_age(slot_age)
    );

    dram_cmd_pick #(
        .DEPTH(DEPTH), .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .AGE_W(AGE_W)
    ) u_pick (
        .clk(clk), .rst_n(rst_n),
        .slot_valid(slot_valid), .slot_bank(slot_bank), .slot_row(slot_row), .slot_age(slot_age),
        .bank_open(bank_open), .bank_row(bank_row), .bank_ready(bank_ready),
        .pick_valid(pick_valid), .pick_idx(pick_idx), .pick_cmd(pick_cmd)
    );

    assign deq_valid = pick_valid && (pick_cmd == CMD_RD);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign issue_act[b] = pick_valid && (pick_cmd == CMD_ACT) && (slot_bank[pick_idx] == BANK_W'(b));
        assign issue_pre[b] = pick_valid && (pick_cmd == CMD_PRE) && (slot_bank[pick_idx] == BANK_W'(b));
        dram_bank_timer #(
            .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RP(T_RP)
        ) u_timer (
            .clk(clk), .rst_n(rst_n),
            .issue_act(issue_act[b]), .issue_pre(issue_pre[b]),
            .act_row(slot_row[pick_idx]),
            .open_o(bank_open[b]), .row_o(bank_row[b]), .ready_o(bank_ready[b])
        );
    end

    always_comb begin
        cmd_valid = pick_valid;
        cmd_type  = pick_valid ? pick_cmd : CMD_NONE;
        cmd_bank  = pick_valid ? slot_bank[pick_idx] : '0;
        cmd_row   = pick_valid ? slot_row[pick_idx]  : '0;
        cmd_col   = pick_valid ? slot_col[pick_idx]  : '0;
    end

    p_rd_on_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_type == CMD_RD) |-> (bank_open[cmd_bank] && bank_row[cmd_bank] == cmd_row));
    p_single_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({issue_act, issue_pre, deq_valid}) <= 1);
    p_quiet_when_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid == '0) |-> !cmd_valid);
endmodule

// File: tb/dram_sched_bench.sv
module dram_sched_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;
    localparam int NB    = 4;
    localparam int ROW_W = 8;
    localparam int COL_W = 6;
    localparam int T_RCD = 3;
    localparam int T_RP  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_bank = '0;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic req_full, cmd_valid;
    logic [1:0] cmd_type, cmd_bank;
    logic [ROW_W-1:0] cmd_row;
    logic [COL_W-1:0] cmd_col;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_sched #(.DEPTH(DEPTH), .NUM_BANKS(NB), .ROW_W(ROW_W), .COL_W(COL_W),
                 .T_RCD(T_RCD), .T_RP(T_RP)) u_dram_sched (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
        .req_row(req_row), .req_col(req_col), .req_full(req_full),
        .cmd_valid(cmd_valid), .cmd_type(cmd_type), .cmd_bank(cmd_bank),
        .cmd_row(cmd_row), .cmd_col(cmd_col));

    int checks = 0, fails = 0, cyc = 0, full_seen = 0;
    bit done = 1'b0;
    int mv[DEPTH], mb[DEPTH], mr[DEPTH], mc[DEPTH], ma[DEPTH];
    int bopen[NB], brow[NB], btmr[NB], last_act[NB], last_pre[NB];
    int stamp = 0;
    int e_valid, e_slot, e_type;

    task automatic check(input bit ok, input string req, input string msg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    function automatic int model_full();
        for (int i = 0; i < DEPTH; i++) if (!mv[i]) return 0;
        return 1;
    endfunction

    // Expected next command: ready banks only (R6), reads first (R7), then oldest (R8)
    function automatic void model_pick();
        int t;
        e_valid = 0; e_slot = 0; e_type = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (mv[i] && btmr[mb[i]] == 0) begin
                t = !bopen[mb[i]] ? 1 : (brow[mb[i]] == mr[i] ? 3 : 2);
                if (!e_valid || (t == 3 && e_type != 3) ||
                    ((t == 3) == (e_type == 3) && ma[i] < ma[e_slot])) begin
                    e_valid = 1; e_slot = i; e_type = t;
                end
            end
        end
    endfunction

    task automatic step(input bit v, input int b, input int r, input int c);
        int mf;
        string tag;
        @(negedge clk);
        req_valid = v; req_bank = 2'(b); req_row = ROW_W'(r); req_col = COL_W'(c);
        #1;
        mf = model_full();
        model_pick();
        check(req_full == mf[0], "R1", $sformatf("req_full act=%0d exp=%0d", req_full, mf));
        if (req_full) full_seen++;
        tag = (e_type == 3) ? "R2" : (e_type == 1) ? "R3" : (e_type == 2) ? "R4" : "R6";
        if (!e_valid)
            check(!cmd_valid && cmd_type == 2'b00, "R9",
                  $sformatf("idle act=%0d/%0d exp=0/0", cmd_valid, cmd_type));
        else
            check(cmd_valid && cmd_type == 2'(e_type) && cmd_bank == 2'(mb[e_slot]) &&
                  cmd_row == ROW_W'(mr[e_slot]) && (e_type != 3 || cmd_col == COL_W'(mc[e_slot])),
                  tag, $sformatf("cmd act=%0d t%0d b%0d r%0d c%0d exp=1 t%0d b%0d r%0d c%0d",
                  cmd_valid, cmd_type, cmd_bank, cmd_row, cmd_col,
                  e_type, mb[e_slot], mr[e_slot], mc[e_slot]));
        // R5 spacing observed at the ports
        if (cmd_valid && cmd_type == 2'b11)
            check(cyc - last_act[cmd_bank] >= T_RCD, "R5",
                  $sformatf("act->rd gap act=%0d exp>=%0d", cyc - last_act[cmd_bank], T_RCD));
        if (cmd_valid && cmd_type == 2'b01)
            check(cyc - last_pre[cmd_bank] >= T_RP, "R5",
                  $sformatf("pre->act gap act=%0d exp>=%0d", cyc - last_pre[cmd_bank], T_RP));
        if (cmd_valid && cmd_type == 2'b01) last_act[cmd_bank] = cyc;
        if (cmd_valid && cmd_type == 2'b10) last_pre[cmd_bank] = cyc;
        // advance model
        for (int k = 0; k < NB; k++) if (btmr[k] > 0) btmr[k]--;
        if (e_valid) begin
            if (e_type == 1) begin bopen[mb[e_slot]] = 1; brow[mb[e_slot]] = mr[e_slot]; btmr[mb[e_slot]] = T_RCD - 1; end
            if (e_type == 2) begin bopen[mb[e_slot]] = 0; btmr[mb[e_slot]] = T_RP - 1; end
        end
        if (v && !mf) begin
            for (int i = 0; i < DEPTH; i++) if (!mv[i]) begin
                mv[i] = 1; mb[i] = b; mr[i] = r; mc[i] = c; ma[i] = stamp; break;
            end
            stamp++;
        end
        if (e_valid && e_type == 3) mv[e_slot] = 0;
        cyc++;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mv[i] = 0;
        for (int k = 0; k < NB; k++) begin
            bopen[k] = 0; brow[k] = 0; btmr[k] = 0; last_act[k] = -100; last_pre[k] = -100;
        end
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: reset state
        check(!req_full && !cmd_valid && cmd_type == 2'b00, "R10",
              $sformatf("after reset full=%0d valid=%0d type=%0d exp=0/0/0", req_full, cmd_valid, cmd_type));
        // Directed: closed bank then hit, interleaved bank, conflict
        step(1, 0, 5, 1);
        step(1, 0, 5, 2);
        step(1, 1, 3, 7);
        step(1, 0, 9, 4);
        repeat (20) step(0, 0, 0, 0);
        // R7/R8: older conflict vs younger hit on open bank 0 row 9
        step(1, 0, 2, 10);
        step(1, 0, 9, 11);
        step(1, 0, 9, 12);
        repeat (20) step(0, 0, 0, 0);
        // R1: flood one bank with conflicting rows so the queue fills
        for (int n = 0; n < 14; n++) step(1, 0, n % 3, n);
        repeat (60) step(0, 0, 0, 0);
        check(full_seen > 0, "R1", $sformatf("full observed act=%0d exp>0", full_seen));
        // Constrained random mix
        for (int n = 0; n < 3000; n++)
            step(($urandom % 10) < 4, $urandom % NB, $urandom % 3, $urandom % 64);
        repeat (200) step(0, 0, 0, 0);
        // R9: everything drained
        check(!cmd_valid && !req_full, "R9", $sformatf("drain valid=%0d full=%0d exp=0/0", cmd_valid, req_full));
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung act=running exp=finished");
            summary();
            $finish;
        end
    end
endmodule